// File: doc/BRIEF.md
# Segmented stream frame packer

The packer takes Ethernet frames from a narrow source and places them on a wide segmented transmit bus. The source offers one 16-byte word per clock with a valid/ready handshake. The word that closes a frame carries a last flag and a count of its valid bytes. The first word of a frame carries a 64-bit preamble value. Each bus cycle has eight 16-byte lanes. The packer fills them in order, starting at lane 0, and hands the cycle over only when every lane is used, or when the newest lane ends a frame and the source has nothing more to offer.

Every lane has its own enable, start flag, end flag and 4-bit empty-byte count. Frames follow one another with no unused lane between them, and a frame may run from lane 7 into lane 0 of the next cycle. The preamble of a frame that starts in the lower half of the bus appears on the low preamble port. The preamble of a frame that starts in the upper half appears on the high port. When the bus ready is low, the presented cycle is held unchanged. When internal storage is full, the source is stalled, so no word is ever lost. Frames are assumed to be at least four words long, which keeps at most one frame start in each half of the bus.

Top module: `segpack_top`

## Requirements
- R1: Every accepted input word appears exactly once on the bus, in acceptance order, lane by lane from lane 0 (lane i occupies out_data bits [128*i+127:128*i]).
- R2: A lane carrying data has its enable set. The start flag is set on the lane that holds a frame's first word, and the end flag on the lane that holds its last word. No start or end flag is set on a disabled lane.
- R3: On an end lane the empty count equals 16 minus the byte count given with the last word, and a byte count of 0 means 16 valid bytes (empty count 0). On every other lane the empty count is 0.
- R4: While input words keep arriving, the next frame's first word goes into the lane right after the previous frame's end lane, and a frame starting in lane 7 continues in lane 0 of the next cycle.
- R5: Enabled lanes are always contiguous from lane 0. A disabled lane follows only an end lane, and such a cycle is released only when no input word is offered. Disabled lanes carry all-zero data.
- R6: A frame starting in lanes 0 to 3 puts its preamble on out_pre_lo, and one starting in lanes 4 to 7 puts it on out_pre_hi. A port whose half holds no start drives zero. Preamble inputs on non-first words have no effect.
- R7: out_valid is high exactly when at least one lane is enabled.
- R8: While out_valid is high and out_ready is low, all bus outputs stay unchanged in the next cycle.
- R9: in_ready goes low only while a full cycle is staged and the presented bus cycle is not being taken. With the bus stalled, exactly 16 words are accepted before in_ready drops.
- R10: After a synchronous active-low reset, out_valid is low, all enables are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted this clock when valid |
| in_data | input | 128 | Input word, 16 bytes |
| in_last | input | 1 | Word closes its frame |
| in_cnt | input | 4 | Valid bytes in the closing word, 0 means 16 |
| in_pre | input | 64 | Preamble value, sampled on a frame's first word |
| out_valid | output | 1 | Bus cycle carries at least one lane |
| out_ready | input | 1 | Bus takes the presented cycle |
| out_data | output | 1024 | Eight lanes of 16 bytes |
| out_ena | output | 8 | Per-lane enable |
| out_sop | output | 8 | Per-lane frame start |
| out_eop | output | 8 | Per-lane frame end |
| out_mty | output | 32 | Per-lane empty-byte count, 4 bits per lane |
| out_pre_lo | output | 64 | Preamble for a start in lanes 0 to 3 |
| out_pre_hi | output | 64 | Preamble for a start in lanes 4 to 7 |

## Verification
The bench aims at frame boundaries that land mid-cycle. The main case is a frame ending in lane 1 that is followed at once by a five-lane frame and then by a frame starting in lane 7. A packer that leaves a gap there, or that steers the lane-7 preamble to the low port, fails the per-cycle flag and preamble checks. A full stall of the bus tests that intake stops after exactly two cycles' worth of words and that the held cycle does not move. A design that drops or overwrites a word would fail the lane-by-lane scoreboard. A final short word with counts of 14, 11 and 0 tests the empty-count arithmetic and its wrap at 16 valid bytes.

// File: rtl/segpack_pkg.sv
// Shared sizes, the per-lane control type and the empty-count helper
// for the segmented frame packer.
package segpack_pkg;
    parameter int unsigned SP_SEGS      = 8;   // lanes per bus cycle
    parameter int unsigned SP_SEG_BYTES = 16;  // bytes per lane
    parameter int unsigned SP_PRE_W     = 64;  // preamble width
    parameter int unsigned SP_PRE_PORTS = 2;   // preamble ports, one per bus slice

    localparam int unsigned SP_SEG_W  = SP_SEG_BYTES * 8;
    localparam int unsigned SP_MTY_W  = $clog2(SP_SEG_BYTES);
    localparam int unsigned SP_IDX_W  = $clog2(SP_SEGS);
    localparam int unsigned SP_FILL_W = $clog2(SP_SEGS + 1);
    localparam int unsigned SP_BUS_W  = SP_SEGS * SP_SEG_W;
    localparam int unsigned SP_MTYB_W = SP_SEGS * SP_MTY_W;

    // Control carried with each lane
    typedef struct packed {
        logic                ena;
        logic                sop;
        logic                eop;
        logic [SP_MTY_W-1:0] mty;
    } seg_ctl_t;

    // Unused bytes of a closing word; a count of zero means a full lane
    function automatic logic [SP_MTY_W-1:0] empty_bytes(input logic [SP_MTY_W-1:0] valid_cnt);
        logic [SP_MTY_W:0] diff;
        diff = (SP_MTY_W + 1)'(SP_SEG_BYTES) - {1'b0, valid_cnt};
        return diff[SP_MTY_W-1:0];
    endfunction
endpackage

// File: rtl/segpack_pre_steer.sv
// Preamble port selection.
// Decodes which bus slice a frame-start lane belongs to and raises the
// write enable of that slice's preamble port. Assumes NUM_SEGS divides
// evenly by NUM_PORTS.
module segpack_pre_steer
    import segpack_pkg::*;
#(
    parameter int unsigned NUM_SEGS  = SP_SEGS,
    parameter int unsigned NUM_PORTS = SP_PRE_PORTS
) (
    input  logic                 sop_we,
    input  logic [SP_IDX_W-1:0]  seg_idx,
    output logic [NUM_PORTS-1:0] port_we
);
    localparam int unsigned SEGS_PER_PORT = NUM_SEGS / NUM_PORTS;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int unsigned LO = p * SEGS_PER_PORT;
        localparam int unsigned HI = LO + SEGS_PER_PORT;
        // Slice membership test for this port
        assign port_we[p] = sop_we && (32'(seg_idx) >= LO) && (32'(seg_idx) < HI);
    end
endmodule

// File: rtl/segpack_stage.sv
// Lane assembly stage.
// Collects one input word per clock into the next free lane, tags it with
// start, end and empty-count, and records frame-start preambles per bus
// slice. Releases the assembled cycle when all lanes are used, or when
// the newest lane ends a frame and no input word is offered. Assumes the
// output register reports through out_free whether it can load this clock.
module segpack_stage
    import segpack_pkg::*;
(
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [SP_SEG_W-1:0]                      in_data,
    input  logic                                     in_last,
    input  logic [SP_MTY_W-1:0]                      in_cnt,
    input  logic [SP_PRE_W-1:0]                      in_pre,
    output logic                                     in_ready,
    input  logic                                     out_free,
    output logic                                     flush_go,
    output logic [SP_SEGS-1:0][SP_SEG_W-1:0]         st_data,
    output seg_ctl_t [SP_SEGS-1:0]                   st_ctl,
    output logic [SP_PRE_PORTS-1:0][SP_PRE_W-1:0]    st_pre
);
    localparam logic [SP_FILL_W-1:0] FILL_MAX = SP_FILL_W'(SP_SEGS);

    logic [SP_FILL_W-1:0]    fill_q;
    logic                    in_frame_q;
    logic                    tail_eop_q;
    logic                    full_w;
    logic                    flush_req;
    logic                    accept;
    logic [SP_IDX_W-1:0]     wr_idx;
    logic [SP_PRE_PORTS-1:0] pre_we;
    seg_ctl_t                new_ctl;

    // Release decision and intake handshake
    assign full_w    = (fill_q == FILL_MAX);
    assign flush_req = full_w || ((fill_q != '0) && tail_eop_q && !in_valid);
    assign flush_go  = flush_req && out_free;
    assign in_ready  = !full_w || flush_go;
    assign accept    = in_valid && in_ready;
    assign wr_idx    = flush_go ? '0 : SP_IDX_W'(fill_q);

    // Control word for the lane being written
    always_comb begin
        new_ctl.ena = 1'b1;
        new_ctl.sop = !in_frame_q;
        new_ctl.eop = in_last;
        new_ctl.mty = in_last ? empty_bytes(in_cnt) : '0;
    end

    segpack_pre_steer #(
        .NUM_SEGS  (SP_SEGS),
        .NUM_PORTS (SP_PRE_PORTS)
    ) i_pre_steer (
        .sop_we  (accept && !in_frame_q),
        .seg_idx (wr_idx),
        .port_we (pre_we)
    );

    // Lane storage, fill level and frame tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q     <= '0;
            in_frame_q <= 1'b0;
            tail_eop_q <= 1'b0;
            st_data    <= '0;
            st_ctl     <= '0;
            st_pre     <= '0;
        end else begin
            if (flush_go) begin
                fill_q  <= '0;
                st_data <= '0;
                st_ctl  <= '0;
                st_pre  <= '0;
            end
            if (accept) begin
                st_data[wr_idx] <= in_data;
                st_ctl[wr_idx]  <= new_ctl;
                fill_q          <= SP_FILL_W'(wr_idx) + 1'b1;
                in_frame_q      <= !in_last;
                tail_eop_q      <= in_last;
            end
            for (int p = 0; p < SP_PRE_PORTS; p++) begin
                if (pre_we[p]) begin
                    st_pre[p] <= in_pre;
                end
            end
        end
    end
endmodule

// File: rtl/segpack_outreg.sv
// Bus output register.
// Loads an assembled cycle when the stage releases one, holds it while
// the bus is not ready, and clears to an idle cycle once taken with
// nothing new behind it. Assumes load is raised only when out_free is high.
module segpack_outreg
    import segpack_pkg::*;
(
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     load,
    input  logic [SP_SEGS-1:0][SP_SEG_W-1:0]         st_data,
    input  seg_ctl_t [SP_SEGS-1:0]                   st_ctl,
    input  logic [SP_PRE_PORTS-1:0][SP_PRE_W-1:0]    st_pre,
    input  logic                                     out_ready,
    output logic                                     out_free,
    output logic                                     o_valid,
    output logic [SP_SEGS-1:0][SP_SEG_W-1:0]         o_data,
    output seg_ctl_t [SP_SEGS-1:0]                   o_ctl,
    output logic [SP_PRE_PORTS-1:0][SP_PRE_W-1:0]    o_pre
);
    // Register may take a new cycle when empty or being drained
    assign out_free = !o_valid || out_ready;

    // Load, hold or drain the presented bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
            o_ctl   <= '0;
            o_pre   <= '0;
        end else if (load) begin
            o_valid <= 1'b1;
            o_data  <= st_data;
            o_ctl   <= st_ctl;
            o_pre   <= st_pre;
        end else if (out_ready) begin
            o_valid <= 1'b0;
            o_data  <= '0;
            o_ctl   <= '0;
            o_pre   <= '0;
        end
    end
endmodule

// File: rtl/segpack_top.sv
// Segmented stream frame packer, top level.
// Connects the lane assembly stage to the bus output register and spreads
// the per-lane control into flat per-lane port vectors. Assumes frames of
// at least four words so each bus slice holds at most one frame start.
module segpack_top
    import segpack_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SP_SEG_W-1:0]   in_data,
    input  logic                  in_last,
    input  logic [SP_MTY_W-1:0]   in_cnt,
    input  logic [SP_PRE_W-1:0]   in_pre,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SP_BUS_W-1:0]   out_data,
    output logic [SP_SEGS-1:0]    out_ena,
    output logic [SP_SEGS-1:0]    out_sop,
    output logic [SP_SEGS-1:0]    out_eop,
    output logic [SP_MTYB_W-1:0]  out_mty,
    output logic [SP_PRE_W-1:0]   out_pre_lo,
    output logic [SP_PRE_W-1:0]   out_pre_hi
);
    logic                                  flush_go;
    logic                                  out_free;
    logic [SP_SEGS-1:0][SP_SEG_W-1:0]      st_data;
    seg_ctl_t [SP_SEGS-1:0]                st_ctl;
    logic [SP_PRE_PORTS-1:0][SP_PRE_W-1:0] st_pre;
    logic [SP_SEGS-1:0][SP_SEG_W-1:0]      o_data;
    seg_ctl_t [SP_SEGS-1:0]                o_ctl;
    logic [SP_PRE_PORTS-1:0][SP_PRE_W-1:0] o_pre;

    segpack_stage i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_cnt   (in_cnt),
        .in_pre   (in_pre),
        .in_ready (in_ready),
        .out_free (out_free),
        .flush_go (flush_go),
        .st_data  (st_data),
        .st_ctl   (st_ctl),
        .st_pre   (st_pre)
    );

    segpack_outreg i_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flush_go),
        .st_data   (st_data),
        .st_ctl    (st_ctl),
        .st_pre    (st_pre),
        .out_ready (out_ready),
        .out_free  (out_free),
        .o_valid   (out_valid),
        .o_data    (o_data),
        .o_ctl     (o_ctl),
        .o_pre     (o_pre)
    );

    // Flatten per-lane fields onto the bus ports
    for (genvar s = 0; s < SP_SEGS; s++) begin : g_lane
        assign out_data[s*SP_SEG_W +: SP_SEG_W] = o_data[s];
        assign out_ena[s]                       = o_ctl[s].ena;
        assign out_sop[s]                       = o_ctl[s].sop;
        assign out_eop[s]                       = o_ctl[s].eop;
        assign out_mty[s*SP_MTY_W +: SP_MTY_W]  = o_ctl[s].mty;
    end

    assign out_pre_lo = o_pre[0];
    assign out_pre_hi = o_pre[SP_PRE_PORTS-1];
endmodule

// File: rtl/segpack_chk.sv
// Protocol checker for segpack_top, attached by bind.
module segpack_chk
    import segpack_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [SP_BUS_W-1:0]  out_data,
    input logic [SP_SEGS-1:0]   out_ena,
    input logic [SP_SEGS-1:0]   out_sop,
    input logic [SP_SEGS-1:0]   out_eop,
    input logic [SP_MTYB_W-1:0] out_mty,
    input logic [SP_PRE_W-1:0]  out_pre_lo,
    input logic [SP_PRE_W-1:0]  out_pre_hi
);
    localparam int unsigned HALF = SP_SEGS / 2;

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ena)
            && $stable(out_sop) && $stable(out_eop) && $stable(out_mty)
            && $stable(out_pre_lo) && $stable(out_pre_hi)));

    a_r7_valid_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ena[0]);

    a_r7_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_ena == '0));

    a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    a_r6_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop[HALF-1:0] == '0) |-> (out_pre_lo == '0));

    a_r6_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop[SP_SEGS-1:HALF] == '0) |-> (out_pre_hi == '0));

    for (genvar s = 0; s < SP_SEGS; s++) begin : g_lane_chk
        a_r2_flags_need_ena: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sop[s] || out_eop[s]) |-> out_ena[s]);

        a_r3_mty_only_eop: assert property (@(posedge clk) disable iff (!rst_n)
            !out_eop[s] |-> (out_mty[s*SP_MTY_W +: SP_MTY_W] == '0));

        if (s > 0) begin : g_pair
            a_r5_contig: assert property (@(posedge clk) disable iff (!rst_n)
                out_ena[s] |-> out_ena[s-1]);

            a_r5_gap_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
                (out_ena[s-1] && !out_ena[s]) |-> out_eop[s-1]);
        end
    end
endmodule

bind segpack_top segpack_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_ena    (out_ena),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_mty    (out_mty),
    .out_pre_lo (out_pre_lo),
    .out_pre_hi (out_pre_hi)
);

// File: tb/test_segpack_top.sv
module test_segpack_top;
    import segpack_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic         rst_n;
    logic         in_valid, in_ready, in_last;
    logic [127:0] in_data;
    logic [3:0]   in_cnt;
    logic [63:0]  in_pre;
    logic         out_valid, out_ready;
    logic [1023:0] out_data;
    logic [7:0]   out_ena, out_sop, out_eop;
    logic [31:0]  out_mty;
    logic [63:0]  out_pre_lo, out_pre_hi;

    segpack_top i_segpack_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_cnt(in_cnt), .in_pre(in_pre),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ena(out_ena), .out_sop(out_sop), .out_eop(out_eop), .out_mty(out_mty),
        .out_pre_lo(out_pre_lo), .out_pre_hi(out_pre_hi)
    );

    typedef struct {
        logic [127:0] d;
        bit           sop;
        bit           eop;
        logic [3:0]   mty;
        logic [63:0]  pre;
    } exp_t;

    exp_t expq[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int acc_count = 0;
    int ready_mode = 0;     // 0 always ready, 1 stalled, 2 random
    bit rec_on = 0;
    int beat_n = 0;
    logic [7:0]  bt_ena[64], bt_sop[64], bt_eop[64];
    logic [31:0] bt_mty[64];
    logic [63:0] bt_lo[64], bt_hi[64];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [3:0] exp_mty(input logic [3:0] cnt);
        return (cnt == 0) ? 4'd0 : 4'(16 - int'(cnt));
    endfunction

    // Send one frame word by word, optionally with idle cycles inside it
    task automatic send_frame(input int len, input int gap_pct, input logic [63:0] pre, input logic [3:0] lastcnt);
        for (int w = 0; w < len; w++) begin
            exp_t e;
            bit acc;
            if (gap_pct > 0) begin
                while ($urandom_range(99) < gap_pct) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    @(posedge clk);
                end
            end
            e.d   = {$urandom, $urandom, $urandom, $urandom};
            e.sop = (w == 0);
            e.eop = (w == len - 1);
            e.mty = e.eop ? exp_mty(lastcnt) : 4'd0;
            e.pre = pre;
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = e.d;
            in_last  = e.eop;
            in_cnt   = e.eop ? lastcnt : 4'($urandom);
            in_pre   = e.sop ? pre : {$urandom, $urandom};
            acc = 0;
            while (!acc) begin
                #1;
                acc = in_ready;
                @(posedge clk);
                if (!acc) @(negedge clk);
            end
            expq.push_back(e);
            acc_count++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Bus ready driver, changed just after each rising edge
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = 1'b0;
                default: out_ready = ($urandom_range(99) < 70);
            endcase
        end
    end

    logic         p_valid = 0, p_ready = 0;
    logic [1023:0] p_data;
    logic [7:0]   p_ena, p_sop, p_eop;
    logic [31:0]  p_mty;
    logic [63:0]  p_lo, p_hi;

    // Per-cycle output monitor and lane scoreboard
    task automatic monitor();
        chk(out_valid == (out_ena != 0), "R7 valid matches lane enables", out_valid, out_ena != 0);
        if (p_valid && !p_ready) begin
            chk(out_data == p_data, "R8 data held", out_data[127:0], p_data[127:0]);
            chk({out_valid, out_ena, out_sop, out_eop, out_mty} == {1'b1, p_ena, p_sop, p_eop, p_mty},
                "R8 control held", {out_ena, out_sop, out_eop, out_mty}, {p_ena, p_sop, p_eop, p_mty});
            chk({out_pre_lo, out_pre_hi} == {p_lo, p_hi}, "R8 preamble held", {out_pre_lo, out_pre_hi}, {p_lo, p_hi});
        end
        if (out_valid && out_ready) begin
            bit contig_ok = 1;
            bit zero_ok = 1;
            for (int s = 1; s < 8; s++) begin
                if (out_ena[s] && !out_ena[s-1]) contig_ok = 0;
                if (out_ena[s-1] && !out_ena[s] && !out_eop[s-1]) contig_ok = 0;
            end
            for (int s = 0; s < 8; s++) begin
                if (!out_ena[s] && out_data[s*128 +: 128] != 0) zero_ok = 0;
            end
            chk(contig_ok, "R5 lanes contiguous, gap only after end", out_ena, out_eop);
            chk(zero_ok, "R5 disabled lanes zero", out_ena, 0);
            if (out_sop[3:0] == 0) chk(out_pre_lo == 0, "R6 low port idle", out_pre_lo, 0);
            if (out_sop[7:4] == 0) chk(out_pre_hi == 0, "R6 high port idle", out_pre_hi, 0);
            for (int s = 0; s < 8; s++) begin
                if (out_ena[s]) begin
                    if (expq.size() == 0) begin
                        chk(0, "R1 unexpected lane", s, -1);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(out_data[s*128 +: 128] == e.d, "R1 lane data", out_data[s*128 +: 128], e.d);
                        chk({out_sop[s], out_eop[s]} == {e.sop, e.eop}, "R2 start/end flags",
                            {out_sop[s], out_eop[s]}, {e.sop, e.eop});
                        chk(out_mty[s*4 +: 4] == e.mty, "R3 empty count", out_mty[s*4 +: 4], e.mty);
                        if (e.sop) begin
                            if (s < 4) chk(out_pre_lo == e.pre, "R6 low port preamble", out_pre_lo, e.pre);
                            else       chk(out_pre_hi == e.pre, "R6 high port preamble", out_pre_hi, e.pre);
                        end
                    end
                end
            end
            if (rec_on && beat_n < 64) begin
                bt_ena[beat_n] = out_ena;
                bt_sop[beat_n] = out_sop;
                bt_eop[beat_n] = out_eop;
                bt_mty[beat_n] = out_mty;
                bt_lo[beat_n]  = out_pre_lo;
                bt_hi[beat_n]  = out_pre_hi;
                beat_n++;
            end
        end
        p_valid = out_valid; p_ready = out_ready; p_data = out_data;
        p_ena = out_ena; p_sop = out_sop; p_eop = out_eop; p_mty = out_mty;
        p_lo = out_pre_lo; p_hi = out_pre_hi;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) monitor();
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] pa, pb, pc, pd;
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_cnt = '0; in_pre = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(out_valid == 0 && out_ena == 0, "R10 outputs idle in reset", {out_valid, out_ena}, 0);
        chk(in_ready == 1, "R10 intake open in reset", in_ready, 1);
        rst_n = 1'b1;

        // Directed packing: mid-cycle ends, back-to-back frames, start in lane 7 (R4)
        pa = 64'hA5A5_0000_1111_2222; pb = 64'hB6B6_3333_4444_5555; pc = 64'hC7C7_6666_7777_8888;
        rec_on = 1; beat_n = 0;
        send_frame(10, 0, pa, 4'd14);
        send_frame(5, 0, pb, 4'd0);
        send_frame(18, 0, pc, 4'd11);
        idle(20);
        rec_on = 0;
        chk(beat_n == 5, "R4 five bus cycles for 33 words", beat_n, 5);
        chk(bt_sop[0] == 8'h01 && bt_lo[0] == pa && bt_hi[0] == 0, "R6 first cycle start lane 0",
            {bt_sop[0], bt_lo[0]}, {8'h01, pa});
        chk(bt_sop[1] == 8'h84, "R4 starts at lanes 2 and 7", bt_sop[1], 8'h84);
        chk(bt_eop[1] == 8'h42, "R2 ends at lanes 1 and 6", bt_eop[1], 8'h42);
        chk(bt_ena[1] == 8'hFF, "R4 no gap between frames", bt_ena[1], 8'hFF);
        chk(bt_mty[1] == 32'h0000_0020, "R3 14 bytes gives 2, 0 gives 0", bt_mty[1], 32'h20);
        chk(bt_lo[1] == pb && bt_hi[1] == pc, "R6 lane-7 start on high port", {bt_lo[1], bt_hi[1]}, {pb, pc});
        chk(bt_ena[4] == 8'h01 && bt_eop[4] == 8'h01, "R5 partial cycle after end", {bt_ena[4], bt_eop[4]}, 16'h0101);
        chk(bt_mty[4] == 32'h5, "R3 11 bytes gives 5", bt_mty[4], 32'h5);

        // Full bus stall: intake stops after two cycles of words (R9)
        ready_mode = 1;
        @(posedge clk); #2;
        acc_count = 0;
        pd = 64'hD8D8_9999_AAAA_BBBB;
        fork
            send_frame(20, 0, pd, 4'd3);
            begin
                repeat (40) @(negedge clk);
                #2;
                chk(acc_count == 16, "R9 words taken during stall", acc_count, 16);
                chk(in_ready == 0 && in_valid == 1, "R9 intake blocked", in_ready, 0);
                chk(out_valid == 1 && out_sop == 8'h01, "R8 stalled cycle presented", {out_valid, out_sop}, 9'h101);
                ready_mode = 0;
            end
        join
        idle(20);
        chk(expq.size() == 0, "R9 no word lost after stall", expq.size(), 0);

        // Random traffic with random backpressure
        ready_mode = 2;
        for (int f = 0; f < 120; f++) begin
            send_frame($urandom_range(4, 14), ($urandom_range(3) == 0) ? $urandom_range(5, 30) : 0,
                       {$urandom, $urandom}, 4'($urandom));
            if ($urandom_range(3) == 0) idle($urandom_range(1, 3));
        end
        idle(10);
        ready_mode = 0;
        idle(40);
        chk(expq.size() == 0, "R1 every word delivered once", expq.size(), 0);
        chk(out_valid == 0, "R7 bus idle at end", out_valid, 0);
        report();
    end
endmodule